// File: doc/BRIEF.md
# Counter-Driven Serial Pattern Generator

This block plays a programmable bit pattern out of a single serial output, one bit per clock, over and over. A free-running step counter walks the select code of an eight-way bit selector. The selector's data inputs are the bits of an eight-bit pattern word, so the output traces the word from bit 0 up to bit 7 and then starts again.

A mode input picks the counter length. In the short mode the counter runs modulo 8 and the pattern repeats every eight clocks. In the long mode the counter runs modulo 16. Its top bit drives the selector's active-low enable, so eight clocks of pattern are followed by eight clocks of forced low. The output is registered. The pattern word and the mode may change at any time without a reset.

Top module: `wave_pattern_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, the counter clears to 0 and `z_o` becomes 0. The first clock edge after reset is released outputs pattern bit 0.
- R2: With `long_mode_i` = 0, `z_o` follows pattern bits 0,1,...,7 on successive clocks and repeats with a period of 8.
- R3: Select code n picks `pattern_i[n]`, where bit 0 is the least significant bit of the word.
- R4: With `long_mode_i` = 1, the sequence has a period of 16 clocks. Counter values 0 to 7 play pattern bits 0 to 7, and counter values 8 to 15 give 0.
- R5: `z_o` is registered. The value visible after a clock edge is the pattern bit chosen by the counter value and by `pattern_i` as they stood just before that edge.
- R6: A change of `pattern_i` takes effect at the next clock edge and neither resets nor disturbs the counter.
- R7: When the mode changes, the counter keeps its low three bits and steps them by one. In the short mode the top counter bit clears at the next edge. When the long mode is entered, counting continues from the current value.
- R8: The selector enable is active low and is driven by the top counter bit in the long mode only. While it is deasserted, `z_o` is 0 whatever the pattern holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pattern_i | input | 8 | Pattern word; bit n is played when the select code is n |
| long_mode_i | input | 1 | 0: modulo-8 counter; 1: modulo-16 counter with gated enable |
| z_o | output | 1 | Registered serial pattern output |

## Verification
The hardest case to reach is a mode switch taken while the long-mode counter sits in its upper, silenced half. There the short mode must drop the top bit but keep stepping the low bits. The stimulus holds the long mode until the counter reaches a known upper value and then flips to the short mode, checking that the pattern resumes at the next index. Random runs also toggle the mode and rewrite the pattern mid-sequence, and a model that follows the counter independently predicts every output bit.

// File: rtl/wg_pkg.sv
package wg_pkg;

    // Width of the pattern word in the default configuration
    localparam int unsigned WG_PAT_W_DEF = 8;

    // Counter length selection
    typedef enum logic {
        WG_MODE_SHORT = 1'b0,   // modulo PAT_W
        WG_MODE_LONG  = 1'b1    // modulo 2*PAT_W, top bit gates the output
    } wg_mode_e;

    // Active-low enable derived from mode and counter top bit
    function automatic logic wg_enable_n(input wg_mode_e mode, input logic top_bit);
        return (mode == WG_MODE_LONG) && top_bit;
    endfunction

endpackage

// File: rtl/wg_step_counter.sv
module wg_step_counter
    import wg_pkg::*;
#(
    parameter int unsigned PAT_W = WG_PAT_W_DEF,
    localparam int unsigned SEL_W = $clog2(PAT_W)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  wg_mode_e         mode_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             top_o
);
    localparam int unsigned CNT_W = SEL_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] low_next;

    assign low_next = cnt_q[SEL_W-1:0] + SEL_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (mode_i == WG_MODE_LONG) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= {1'b0, low_next};
        end
    end

    assign sel_o = cnt_q[SEL_W-1:0];
    assign top_o = cnt_q[SEL_W];

    // R7: short mode never leaves the top bit set after a step
    p_short_top_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == WG_MODE_SHORT) |=> !top_o);

    // R2: short-mode wrap from the last index to zero
    p_short_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == WG_MODE_SHORT && sel_o == '1) |=> (sel_o == '0 && !top_o));

    // R4: long-mode wrap from the last count to zero
    p_long_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == WG_MODE_LONG && sel_o == '1 && top_o) |=> (sel_o == '0 && !top_o));

endmodule

// File: rtl/wg_bit_select.sv
module wg_bit_select
    import wg_pkg::*;
#(
    parameter int unsigned PAT_W = WG_PAT_W_DEF,
    localparam int unsigned SEL_W = $clog2(PAT_W)
) (
    input  logic [PAT_W-1:0] data_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_n_i,
    output logic             y_o
);
    logic [PAT_W-1:0] hit;

    for (genvar g = 0; g < PAT_W; g++) begin : g_lane
        assign hit[g] = (sel_i == SEL_W'(g)) && data_i[g];
    end

    assign y_o = !en_n_i && (|hit);

endmodule

// File: rtl/wave_pattern_gen.sv
module wave_pattern_gen
    import wg_pkg::*;
#(
    parameter int unsigned PAT_W = WG_PAT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [PAT_W-1:0] pattern_i,
    input  logic             long_mode_i,
    output logic             z_o
);
    localparam int unsigned SEL_W = $clog2(PAT_W);

    wg_mode_e         mode;
    logic [SEL_W-1:0] sel;
    logic             top;
    logic             en_n;
    logic             bit_d;

    assign mode = wg_mode_e'(long_mode_i);

    wg_step_counter #(.PAT_W(PAT_W)) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .mode_i(mode),
        .sel_o (sel),
        .top_o (top)
    );

    assign en_n = wg_enable_n(mode, top);

    wg_bit_select #(.PAT_W(PAT_W)) u_sel (
        .data_i(pattern_i),
        .sel_i (sel),
        .en_n_i(en_n),
        .y_o   (bit_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            z_o <= 1'b0;
        end else begin
            z_o <= bit_d;
        end
    end

    // R8: silenced half of the long sequence yields a low output
    p_silenced_low_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (long_mode_i && top) |=> !z_o);

    // R5: enabled output is the selected pattern bit one clock later
    p_latency_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(long_mode_i && top) |=> (z_o == $past(pattern_i[sel])));

endmodule

// File: tb/sim_wave_pattern_gen.sv
`timescale 1ns/1ps
module sim_wave_pattern_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pat;
    logic       lng;
    logic       z;

    int checks = 0;
    int fails  = 0;
    logic [3:0] mcnt = 4'd0;

    always #2.5 clk = ~clk;

    wave_pattern_gen u0 (
        .clk_i      (clk),
        .rst_i      (rst),
        .pattern_i  (pat),
        .long_mode_i(lng),
        .z_o        (z)
    );

    function automatic logic exp_bit(input logic r, input logic l,
                                     input logic [3:0] c, input logic [7:0] p);
        if (r) return 1'b0;
        if (l && c[3]) return 1'b0;
        return p[c[2:0]];
    endfunction

    function automatic logic [3:0] next_cnt(input logic r, input logic l, input logic [3:0] c);
        if (r) return 4'd0;
        if (l) return c + 4'd1;
        return {1'b0, c[2:0] + 3'd1};
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: z_o=%b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Called with inputs settled after a falling edge
    task automatic step(input string tag);
        logic  e;
        string t;
        e = exp_bit(rst, lng, mcnt, pat);
        t = (!rst && lng && mcnt[3]) ? {tag, " R8"} : tag;
        @(posedge clk);
        #1;
        check(z, e, t);
        mcnt = next_cnt(rst, lng, mcnt);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        rst = 1'b1;
        pat = 8'hFF;
        lng = 1'b0;
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst = 1'b0;
        // first output after release is bit 0
        step("R1 first bit");
        // R2/R3: walking one in short mode
        rst = 1'b1; step("R1"); rst = 1'b0;
        pat = 8'b0000_0100;
        repeat (16) step("R2 R3 walk");
        pat = 8'b1000_0001;
        repeat (16) step("R2 R3 ends");
        // R4: long mode with all ones
        pat = 8'hFF;
        lng = 1'b1;
        rst = 1'b1; step("R1"); rst = 1'b0;
        repeat (32) step("R4 long");
        // R7: switch to short mode while in silenced half
        while (mcnt != 4'd11) step("R4 approach");
        lng = 1'b0;
        repeat (10) step("R7 switch down");
        // R7: switch back up mid-count
        lng = 1'b1;
        repeat (12) step("R7 switch up");
        // R6: pattern change mid-run without reset
        lng = 1'b0;
        pat = 8'hAA;
        repeat (3) step("R6 before");
        pat = 8'h55;
        repeat (9) step("R6 after");
        // R8: long mode, pattern ones, silenced half must stay low
        lng = 1'b1;
        pat = 8'hFF;
        repeat (20) step("R8 gate");
        // random mix
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 8) == 0) pat = 8'($urandom);
            if (($urandom % 20) == 0) lng = ~lng;
            if (($urandom % 150) == 0) rst = 1'b1; else rst = 1'b0;
            step(lng ? "R4 R5 rand" : "R2 R5 rand");
        end
        rst = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule